// File: doc/BRIEF.md
# Open-Drain General-Purpose I/O Port

This block is one port of eight general-purpose pins with open-drain outputs. A memory-mapped data register holds an output latch. A latch bit of 0 turns on the pin's pull-down. A latch bit of 1 releases the pin, so an external pull-up or an external driver sets the level. Software reads the data register over a byte-wide strobe interface. An ordinary read returns the synchronized pin levels. A read flagged as part of a read-modify-write instruction returns the latch instead, so bits the instruction does not touch are written back unchanged.

Each pin can be handed to a peripheral, bit by bit. The peripheral's output value then drives that pin's pull-down, and a synchronized copy of the pin level is returned to the peripheral on an idle-high input. A parameter adds a per-bit analog-enable register. An enabled bit routes the pin to the analog path and forces its digital input to 0. Three standby conditions release every driver and block the digital inputs: stop, timer-standby together with the pin-level bit, and hardware standby.

Top module: `od_gpio_port`

## Requirements
- R1: After reset, the pull-down enable of every pin is off. Analog enables and bus read data are 0, and the peripheral inputs are all 1s. A read-modify-write read of the data register returns all 1s.
- R2: A write to the data register (`bus_sel`=0) loads the latch. Two clock edges after the write edge, `pin_pd_en` is the inverted latch for every port-mode bit that is not in standby.
- R3: An ordinary data read (`bus_rmw`=0) returns the pin levels after a two-flop synchronizer. The result appears on `bus_rdata` at the edge that samples the read strobe, and it holds while no read is issued.
- R4: A data read with `bus_rmw`=1 returns the output latch, whatever the pin levels are.
- R5: When `periph_sel[i]`=1, `periph_out[i]` drives pin i's pull-down: 0 pulls the pin low and 1 releases it. The latch bit has no effect on that pin.
- R6: Standby is active when `stop_mode` is set, or `tbt_mode` and `spl_bit` are both set, or `hw_standby` is set. While it is active, every `pin_pd_en` bit is 0, digital reads return 0, and `periph_in` is all 1s.
- R7: The analog-enable register is written and read with `bus_sel`=1. It drives `ana_route`. An enabled bit reads 0 on a digital data read and holds `periph_in` at 1.
- R8: For a bit that is neither analog-enabled nor in standby, `periph_in` follows the synchronized pin level.
- R9: `tbt_mode` without `spl_bit` does not gate the drivers or the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_sel | input | 1 | Register select: 0 data latch, 1 analog enable |
| bus_rmw | input | 1 | Read belongs to a read-modify-write instruction |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Registered read data |
| periph_sel | input | WIDTH | Per-bit peripheral ownership |
| periph_out | input | WIDTH | Peripheral output values |
| periph_in | output | WIDTH | Synchronized pin level to the peripheral, idle-high |
| stop_mode | input | 1 | Stop mode active |
| tbt_mode | input | 1 | Timer-standby mode active |
| spl_bit | input | 1 | Pin-level-in-standby bit |
| hw_standby | input | 1 | Hardware standby active |
| pin_in | input | WIDTH | Pin levels seen at the pads |
| pin_pd_en | output | WIDTH | Pull-down enable; 0 leaves the pin tri-stated |
| ana_route | output | WIDTH | Per-bit routing to the analog path |

## Verification
The bench drives several latch patterns (0xA5, 0x00) against pin patterns that differ from them (0x3C, 0xC3, 0x55). This separates a pin read from a latch read in every bit position. A mixed ownership mask pairs peripheral values with latch values that disagree, so the output must take each bit from the right source. Each standby condition is applied on its own, timer-standby both with and without the pin-level bit, so each term of the gating is tested separately. The analog mask covers only the upper half of the pins, so gated and ungated bits appear in the same read.

// File: rtl/od_gpio_pkg.sv
package od_gpio_pkg;
  typedef enum logic {SEL_DATA = 1'b0, SEL_ANA = 1'b1} reg_sel_e;

  function automatic logic standby_active(input logic stop_m, input logic tbt_m,
                                          input logic spl, input logic hw_sb);
    return stop_m | (tbt_m & spl) | hw_sb;
  endfunction
endpackage

// File: rtl/od_sync.sv
module od_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '1;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/od_regs.sv
module od_regs
  import od_gpio_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter bit HAS_ANALOG = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  reg_sel_e         sel,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] ana_q
);
  always_ff @(posedge clk) begin
    if (rst) latch_q <= '1;
    else if (wr && sel == SEL_DATA) latch_q <= wdata;
  end

  generate
    if (HAS_ANALOG) begin : g_ana
      logic [WIDTH-1:0] ana_r;
      always_ff @(posedge clk) begin
        if (rst) ana_r <= '0;
        else if (wr && sel == SEL_ANA) ana_r <= wdata;
      end
      assign ana_q = ana_r;
    end else begin : g_no_ana
      assign ana_q = '0;
    end
  endgenerate
endmodule

// File: rtl/od_pin_slice.sv
module od_pin_slice #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             standby,
  input  logic [WIDTH-1:0] latch_q,
  input  logic [WIDTH-1:0] ana_q,
  input  logic [WIDTH-1:0] periph_sel,
  input  logic [WIDTH-1:0] periph_out,
  input  logic [WIDTH-1:0] pin_sync,
  output logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] pd_en,
  output logic [WIDTH-1:0] periph_in
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic drive_val;
    logic in_open;

    assign drive_val = periph_sel[i] ? periph_out[i] : latch_q[i];
    assign in_open   = ~standby & ~ana_q[i];
    assign din[i]    = in_open & pin_sync[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        pd_en[i]     <= 1'b0;
        periph_in[i] <= 1'b1;
      end else begin
        pd_en[i]     <= ~standby & ~drive_val;
        periph_in[i] <= in_open ? pin_sync[i] : 1'b1;
      end
    end
  end
endmodule

// File: rtl/od_gpio_port.sv
module od_gpio_port
  import od_gpio_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit HAS_ANALOG  = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic             bus_sel,
  input  logic             bus_rmw,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] periph_sel,
  input  logic [WIDTH-1:0] periph_out,
  output logic [WIDTH-1:0] periph_in,
  input  logic             stop_mode,
  input  logic             tbt_mode,
  input  logic             spl_bit,
  input  logic             hw_standby,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_pd_en,
  output logic [WIDTH-1:0] ana_route
);
  reg_sel_e         sel;
  logic             standby;
  logic [WIDTH-1:0] latch_q, ana_q, pin_sync, din;

  assign sel     = reg_sel_e'(bus_sel);
  assign standby = standby_active(stop_mode, tbt_mode, spl_bit, hw_standby);

  od_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_sync)
  );

  od_regs #(.WIDTH(WIDTH), .HAS_ANALOG(HAS_ANALOG)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .sel(sel), .wdata(bus_wdata),
    .latch_q(latch_q), .ana_q(ana_q)
  );

  od_pin_slice #(.WIDTH(WIDTH)) u_pins (
    .clk(clk), .rst(rst), .standby(standby), .latch_q(latch_q), .ana_q(ana_q),
    .periph_sel(periph_sel), .periph_out(periph_out), .pin_sync(pin_sync),
    .din(din), .pd_en(pin_pd_en), .periph_in(periph_in)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      if (sel == SEL_ANA) bus_rdata <= ana_q;
      else                bus_rdata <= bus_rmw ? latch_q : din;
    end
  end

  assign ana_route = ana_q;
endmodule

// File: rtl/od_gpio_port_chk.sv
module od_gpio_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic             bus_sel,
  input logic [WIDTH-1:0] bus_wdata,
  input logic [WIDTH-1:0] bus_rdata,
  input logic [WIDTH-1:0] periph_sel,
  input logic [WIDTH-1:0] periph_in,
  input logic             stop_mode,
  input logic             tbt_mode,
  input logic             spl_bit,
  input logic             hw_standby,
  input logic [WIDTH-1:0] pin_pd_en,
  input logic [WIDTH-1:0] ana_route
);
  logic sb;
  assign sb = stop_mode | (tbt_mode & spl_bit) | hw_standby;

  AST_STBY_RELEASE: assert property (@(posedge clk) disable iff (rst)
    sb |=> (pin_pd_en == '0)); // R6

  AST_STBY_PERIPH_IDLE: assert property (@(posedge clk) disable iff (rst)
    sb |=> (periph_in == '1)); // R6

  AST_ANA_PERIPH_IDLE: assert property (@(posedge clk) disable iff (rst)
    (ana_route != '0) |=> ((periph_in & $past(ana_route)) == $past(ana_route))); // R7

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R3

  AST_WRITE_DRIVE: assert property (@(posedge clk) disable iff (rst)
    ($past(rst, 2) == 1'b0 && $past(rst) == 1'b0 &&
     $past(bus_wr && !bus_sel, 2) && $past(periph_sel) == '0 && !$past(sb))
    |-> (pin_pd_en == ~$past(bus_wdata, 2))); // R2
endmodule

bind od_gpio_port od_gpio_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .periph_sel(periph_sel),
  .periph_in(periph_in), .stop_mode(stop_mode), .tbt_mode(tbt_mode),
  .spl_bit(spl_bit), .hw_standby(hw_standby), .pin_pd_en(pin_pd_en),
  .ana_route(ana_route)
);

// File: tb/tb_od_gpio_port.sv
`timescale 1ns/1ps
module tb_od_gpio_port;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0, bus_sel = 0, bus_rmw = 0;
  logic [W-1:0] bus_wdata = '0, bus_rdata;
  logic [W-1:0] periph_sel = '0, periph_out = '1, periph_in;
  logic stop_mode = 0, tbt_mode = 0, spl_bit = 0, hw_standby = 0;
  logic [W-1:0] pin_in = '1, pin_pd_en, ana_route;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  od_gpio_port #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
    .bus_rmw(bus_rmw), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .periph_sel(periph_sel), .periph_out(periph_out), .periph_in(periph_in),
    .stop_mode(stop_mode), .tbt_mode(tbt_mode), .spl_bit(spl_bit),
    .hw_standby(hw_standby), .pin_in(pin_in), .pin_pd_en(pin_pd_en),
    .ana_route(ana_route)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic sel, input logic [W-1:0] d);
    bus_wr = 1; bus_sel = sel; bus_wdata = d;
    cyc(1);
    bus_wr = 0;
  endtask

  task automatic rd_reg(input logic sel, input logic rmw, output logic [W-1:0] d);
    bus_rd = 1; bus_sel = sel; bus_rmw = rmw;
    cyc(1);
    bus_rd = 0; bus_rmw = 0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [W-1:0] r;
    check("R1 pd_en", pin_pd_en, '0);
    check("R1 ana_route", ana_route, '0);
    check("R1 periph_in", periph_in, '1);
    check("R1 rdata", bus_rdata, '0);
    rd_reg(1'b0, 1'b1, r); check("R1 rmw latch", r, 8'hFF);
    rd_reg(1'b1, 1'b0, r); check("R1 R7 analog reg", r, 8'h00);
  endtask

  task automatic t_drive();
    wr_reg(1'b0, 8'hA5); cyc(1);
    check("R2 pd_en A5", pin_pd_en, 8'h5A);
    wr_reg(1'b0, 8'h0F); cyc(1);
    check("R2 pd_en 0F", pin_pd_en, 8'hF0);
    wr_reg(1'b0, 8'hA5); cyc(1);
  endtask

  task automatic t_read();
    logic [W-1:0] r;
    pin_in = 8'h3C; cyc(3);
    rd_reg(1'b0, 1'b0, r); check("R3 pin read 3C", r, 8'h3C);
    rd_reg(1'b0, 1'b1, r); check("R4 rmw read", r, 8'hA5);
    pin_in = 8'hC3; cyc(3);
    rd_reg(1'b0, 1'b0, r); check("R3 pin read C3", r, 8'hC3);
    cyc(3);
    check("R3 rdata hold", bus_rdata, 8'hC3);
    rd_reg(1'b0, 1'b1, r); check("R4 rmw read vs C3", r, 8'hA5);
  endtask

  task automatic t_periph();
    periph_sel = 8'h0F; periph_out = 8'h0A; cyc(2);
    check("R5 mixed ownership", pin_pd_en, 8'h55);
    pin_in = 8'h96; cyc(3);
    check("R8 periph_in", periph_in, 8'h96);
    periph_sel = 8'h00; periph_out = 8'hFF; cyc(2);
  endtask

  task automatic t_standby();
    logic [W-1:0] r;
    wr_reg(1'b0, 8'h00); pin_in = 8'h5A; cyc(3);
    check("R2 pd_en 00", pin_pd_en, 8'hFF);
    stop_mode = 1; cyc(2);
    check("R6 stop pd_en", pin_pd_en, 8'h00);
    check("R6 stop periph_in", periph_in, 8'hFF);
    rd_reg(1'b0, 1'b0, r); check("R6 stop read", r, 8'h00);
    stop_mode = 0; tbt_mode = 1; cyc(2);
    check("R9 tbt only pd_en", pin_pd_en, 8'hFF);
    rd_reg(1'b0, 1'b0, r); check("R9 tbt only read", r, 8'h5A);
    spl_bit = 1; cyc(2);
    check("R6 tbt+spl pd_en", pin_pd_en, 8'h00);
    rd_reg(1'b0, 1'b0, r); check("R6 tbt+spl read", r, 8'h00);
    tbt_mode = 0; spl_bit = 0; hw_standby = 1; cyc(2);
    check("R6 hw pd_en", pin_pd_en, 8'h00);
    check("R6 hw periph_in", periph_in, 8'hFF);
    hw_standby = 0; cyc(2);
    check("R6 exit pd_en", pin_pd_en, 8'hFF);
  endtask

  task automatic t_analog();
    logic [W-1:0] r;
    wr_reg(1'b1, 8'hF0);
    pin_in = 8'h55; cyc(3);
    rd_reg(1'b1, 1'b0, r); check("R7 analog readback", r, 8'hF0);
    check("R7 ana_route", ana_route, 8'hF0);
    rd_reg(1'b0, 1'b0, r); check("R7 digital read", r, 8'h05);
    check("R7 periph_in", periph_in, 8'hF5);
    rd_reg(1'b0, 1'b1, r); check("R7 R4 latch untouched", r, 8'h00);
  endtask

  initial begin
    cyc(3);
    rst = 0;
    cyc(1);
    t_reset();
    t_drive();
    t_read();
    t_periph();
    t_standby();
    t_analog();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule